// File: doc/BRIEF.md
# Indirect Configuration Access Bridge

This block sits between a host register port and a set of configuration-space targets. The host sees two registers. The first is a 32-bit address latch that selects a bus, a device/function and a register offset, and that carries an enable bit. The second is a four-byte data window. Each access to the data window becomes one configuration read or write toward the target that the latched address selects. The byte offset of the window access is merged into the low address bits, so the host can reach individual byte lanes.

For each target the bridge receives its bus number, its device/function number and four status inputs: present, powered, hotplugged and function-0-present. It uses these to decide whether an access may reach the target. A filtered read returns all ones and a filtered write has no effect. When an access would run past the end of the 256-byte configuration space, its length is clipped. In read data, bytes beyond the clipped length come back as ones. Every host request is accepted in the cycle it is presented. A read answers with a one-cycle response in the next cycle.

Top module: `cfg_bridge`

## Requirements
- R1: The address latch loads the write data only on a host write to the address register (sel = 0) with length 4 and byte offset 0. Address-register writes of any other length or offset leave it unchanged, and no address-register access forwards a request.
- R2: A read of the address register (sel = 0) returns the full 32-bit latch contents, whatever the requested length and offset.
- R3: After reset the latch holds zero. The data window therefore starts disabled, and no response or forwarded request is active.
- R4: When latch bit 31 is 0, data-window reads (sel = 1) return 0xFFFFFFFF and no request is forwarded, for reads or for writes.
- R5: A forwarded request carries bus = latch[23:16] and device/function = latch[15:8]. Its offset is latch[7:0] ORed with the two-bit window offset. It also carries the write flag and the unchanged host write data.
- R6: If no target that is present has a matching bus and device/function number, a read returns 0xFFFFFFFF and nothing is forwarded.
- R7: If the selected target is not powered, a read returns 0xFFFFFFFF and nothing is forwarded.
- R8: A target that is hotplugged while its function-0-present input is low is hidden: it reads as all ones and ignores writes. A hotplugged target whose function 0 is present is reachable.
- R9: The forwarded length is the smaller of the host length and 256 minus the offset.
- R10: Every accepted read gives rsp_valid_o high in the next cycle, and writes give no response. In forwarded read data, bytes at lane index equal to or greater than the clipped length are 0xFF, and the lower lanes pass through from the target.
- R11: A data-window access with length 0 or above 4 is filtered: a read returns 0xFFFFFFFF and nothing is forwarded.
- R12: When several present targets match, the lowest index is selected. cfg_tgt_o is one-hot while a request is forwarded and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Host request ready, held high |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_sel_i | input | 1 | 0 = address register, 1 = data window |
| req_off_i | input | 2 | Byte offset within the register |
| req_len_i | input | 3 | Access length in bytes |
| req_wdata_i | input | 32 | Host write data |
| rsp_valid_o | output | 1 | Read response valid |
| rsp_rdata_o | output | 32 | Read response data |
| tgt_bus_i | input | N_TGT x 8 | Bus number of each target |
| tgt_devfn_i | input | N_TGT x 8 | Device/function number of each target |
| tgt_present_i | input | N_TGT | Target exists |
| tgt_powered_i | input | N_TGT | Target has power |
| tgt_hotplug_i | input | N_TGT | Target was hotplugged |
| tgt_fn0_i | input | N_TGT | Function 0 of the target's device exists |
| cfg_valid_o | output | 1 | Forwarded configuration request |
| cfg_write_o | output | 1 | Forwarded request is a write |
| cfg_tgt_o | output | N_TGT | One-hot selected target |
| cfg_bus_o | output | 8 | Forwarded bus number |
| cfg_devfn_o | output | 8 | Forwarded device/function number |
| cfg_offset_o | output | 8 | Forwarded register offset |
| cfg_len_o | output | 3 | Clipped access length |
| cfg_wdata_o | output | 32 | Forwarded write data |
| cfg_rdata_i | input | 32 | Target read data for the forwarded request, same cycle |

## Verification
The assertions assume that the target status inputs and the identity inputs stay stable while a request is presented. They also assume that cfg_rdata_i answers combinationally in the same cycle. The bench changes the target configuration only between accesses and models each target as a combinational function of the forwarded bus, device/function and offset. Host lengths mostly stay between 1 and 4. A small share of 0 and out-of-range lengths is injected on purpose, so that the filtering of R11 is exercised rather than assumed away.

// File: rtl/cfg_bridge_pkg.sv
package cfg_bridge_pkg;
  localparam int unsigned DW    = 32;
  localparam int unsigned LEN_W = 3;
  localparam int unsigned ID_W  = 8;

  typedef enum logic {
    SEL_ADDR = 1'b0,
    SEL_DATA = 1'b1
  } host_sel_e;

  typedef struct packed {
    logic [ID_W-1:0] bus;
    logic [ID_W-1:0] devfn;
  } tgt_id_t;
endpackage

// File: rtl/cfg_addr_latch.sv
module cfg_addr_latch
  import cfg_bridge_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [1:0]       off_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    addr_o
);
  logic upd;
  assign upd = wr_i && (len_i == LEN_W'(4)) && (off_i == 2'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  addr_o <= '0;
    else if (upd) addr_o <= wdata_i;
  end

  // partial or misaligned writes must not disturb the latch
  p_latch_ignore_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !(len_i == LEN_W'(4) && off_i == 2'd0)) |=> $stable(addr_o));
  p_latch_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && len_i == LEN_W'(4) && off_i == 2'd0) |=> (addr_o == $past(wdata_i)));
endmodule

// File: rtl/cfg_target_match.sv
module cfg_target_match
  import cfg_bridge_pkg::*;
#(
  parameter int unsigned N_TGT = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  tgt_id_t                    id_i,
  input  logic [N_TGT-1:0][ID_W-1:0] tgt_bus_i,
  input  logic [N_TGT-1:0][ID_W-1:0] tgt_devfn_i,
  input  logic [N_TGT-1:0]           tgt_present_i,
  input  logic [N_TGT-1:0]           tgt_powered_i,
  input  logic [N_TGT-1:0]           tgt_hotplug_i,
  input  logic [N_TGT-1:0]           tgt_fn0_i,
  output logic                       hit_o,
  output logic                       visible_o,
  output logic [N_TGT-1:0]           sel_o
);
  logic [N_TGT-1:0] match;

  for (genvar i = 0; i < N_TGT; i++) begin : g_cmp
    assign match[i] = tgt_present_i[i] &&
                      (tgt_bus_i[i] == id_i.bus) &&
                      (tgt_devfn_i[i] == id_i.devfn);
  end

  // isolate lowest set bit: lowest index wins
  assign sel_o = match & (~match + N_TGT'(1));
  assign hit_o = |match;
  // powered and not an orphaned hotplugged function
  assign visible_o = |(sel_o & tgt_powered_i & ~(tgt_hotplug_i & ~tgt_fn0_i));

  p_sel_onehot_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));
  p_sel_lowest_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o != '0) |-> (((sel_o - N_TGT'(1)) & match) == '0));
  p_hit_sel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ($countones(sel_o) == 1));
endmodule

// File: rtl/cfg_len_clip.sv
module cfg_len_clip
  import cfg_bridge_pkg::*;
#(
  parameter int unsigned CFG_SPACE = 256,
  localparam int unsigned OFF_W = $clog2(CFG_SPACE)
) (
  input  logic [OFF_W-1:0] offset_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [DW-1:0]    raw_i,
  output logic             ok_o,
  output logic [LEN_W-1:0] len_o,
  output logic [DW-1:0]    data_o
);
  localparam int unsigned NB = DW / 8;
  localparam logic [OFF_W:0] SPACE = (OFF_W+1)'(CFG_SPACE);

  logic [OFF_W:0] room;
  logic [OFF_W:0] len_x;
  logic           in_range;
  logic           len_legal;

  assign room      = SPACE - {1'b0, offset_i};
  assign len_x     = (OFF_W+1)'(len_i);
  assign in_range  = {1'b0, offset_i} < SPACE;
  assign len_legal = (len_i != '0) && (len_i <= LEN_W'(NB));
  assign ok_o      = in_range && len_legal;
  assign len_o     = (len_x > room) ? room[LEN_W-1:0] : len_i;

  for (genvar k = 0; k < NB; k++) begin : g_lane
    assign data_o[8*k +: 8] = (LEN_W'(k) < len_o) ? raw_i[8*k +: 8] : 8'hFF;
  end
endmodule

// File: rtl/cfg_bridge.sv
module cfg_bridge
  import cfg_bridge_pkg::*;
#(
  parameter int unsigned N_TGT     = 4,
  parameter int unsigned CFG_SPACE = 256,
  localparam int unsigned OFF_W    = $clog2(CFG_SPACE)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_valid_i,
  output logic                       req_ready_o,
  input  logic                       req_write_i,
  input  logic                       req_sel_i,
  input  logic [1:0]                 req_off_i,
  input  logic [LEN_W-1:0]           req_len_i,
  input  logic [DW-1:0]              req_wdata_i,
  output logic                       rsp_valid_o,
  output logic [DW-1:0]              rsp_rdata_o,
  input  logic [N_TGT-1:0][ID_W-1:0] tgt_bus_i,
  input  logic [N_TGT-1:0][ID_W-1:0] tgt_devfn_i,
  input  logic [N_TGT-1:0]           tgt_present_i,
  input  logic [N_TGT-1:0]           tgt_powered_i,
  input  logic [N_TGT-1:0]           tgt_hotplug_i,
  input  logic [N_TGT-1:0]           tgt_fn0_i,
  output logic                       cfg_valid_o,
  output logic                       cfg_write_o,
  output logic [N_TGT-1:0]           cfg_tgt_o,
  output logic [ID_W-1:0]            cfg_bus_o,
  output logic [ID_W-1:0]            cfg_devfn_o,
  output logic [OFF_W-1:0]           cfg_offset_o,
  output logic [LEN_W-1:0]           cfg_len_o,
  output logic [DW-1:0]              cfg_wdata_o,
  input  logic [DW-1:0]              cfg_rdata_i
);
  logic [DW-1:0]    addr_q;
  logic             addr_wr, data_acc, allow;
  logic             hit, visible, len_ok;
  logic [N_TGT-1:0] sel;
  tgt_id_t          id;
  logic [DW-1:0]    masked;

  assign req_ready_o = 1'b1;
  assign addr_wr  = req_valid_i && req_write_i && (host_sel_e'(req_sel_i) == SEL_ADDR);
  assign data_acc = req_valid_i && (host_sel_e'(req_sel_i) == SEL_DATA);

  cfg_addr_latch i_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (addr_wr),
    .off_i   (req_off_i),
    .len_i   (req_len_i),
    .wdata_i (req_wdata_i),
    .addr_o  (addr_q)
  );

  assign id.bus   = addr_q[23:16];
  assign id.devfn = addr_q[15:8];
  assign cfg_offset_o = {addr_q[OFF_W-1:2], addr_q[1:0] | req_off_i};

  cfg_target_match #(.N_TGT(N_TGT)) i_match (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .id_i          (id),
    .tgt_bus_i     (tgt_bus_i),
    .tgt_devfn_i   (tgt_devfn_i),
    .tgt_present_i (tgt_present_i),
    .tgt_powered_i (tgt_powered_i),
    .tgt_hotplug_i (tgt_hotplug_i),
    .tgt_fn0_i     (tgt_fn0_i),
    .hit_o         (hit),
    .visible_o     (visible),
    .sel_o         (sel)
  );

  cfg_len_clip #(.CFG_SPACE(CFG_SPACE)) i_clip (
    .offset_i (cfg_offset_o),
    .len_i    (req_len_i),
    .raw_i    (cfg_rdata_i),
    .ok_o     (len_ok),
    .len_o    (cfg_len_o),
    .data_o   (masked)
  );

  assign allow       = addr_q[31] && hit && visible && len_ok;
  assign cfg_valid_o = data_acc && allow;
  assign cfg_write_o = req_write_i;
  assign cfg_tgt_o   = cfg_valid_o ? sel : '0;
  assign cfg_bus_o   = id.bus;
  assign cfg_devfn_o = id.devfn;
  assign cfg_wdata_o = req_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i && !req_write_i;
      if (req_valid_i && !req_write_i)
        rsp_rdata_o <= (host_sel_e'(req_sel_i) == SEL_ADDR) ? addr_q :
                       (allow ? masked : '1);
    end
  end

  p_fwd_enable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o |-> addr_q[31]);
  p_fwd_powered_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o |-> |(cfg_tgt_o & tgt_powered_i));
  p_fwd_visible_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o |-> !(|(cfg_tgt_o & tgt_hotplug_i & ~tgt_fn0_i)));
  p_len_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o |-> (cfg_len_o != '0 && cfg_len_o <= req_len_i &&
                     (int'(cfg_offset_o) + int'(cfg_len_o)) <= int'(CFG_SPACE)));
  p_len_legal_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o |-> (req_len_i >= LEN_W'(1) && req_len_i <= LEN_W'(4)));
  p_rd_rsp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i) |=> rsp_valid_o);
  p_wr_norsp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i) |=> !rsp_valid_o);
  p_tgt_onehot_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o |-> ($countones(cfg_tgt_o) == 1));
endmodule

// File: tb/test_cfg_bridge.sv
module test_cfg_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0, req_sel = 1'b0;
  logic [1:0] req_off = '0;
  logic [2:0] req_len = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic [N-1:0][7:0] t_bus = '0, t_devfn = '0;
  logic [N-1:0] t_pres = '0, t_pwr = '0, t_hp = '0, t_fn0 = '0;
  logic cfg_valid, cfg_write;
  logic [N-1:0] cfg_tgt;
  logic [7:0] cfg_bus, cfg_devfn, cfg_offset;
  logic [2:0] cfg_len;
  logic [31:0] cfg_wdata, cfg_rdata;

  int checks = 0, errors = 0;
  logic [31:0] m_latch = '0;
  logic c_valid, c_write;
  logic [N-1:0] c_tgt;
  logic [7:0] c_bus, c_devfn, c_off;
  logic [2:0] c_len;
  logic [31:0] c_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;
  // target model: data is a function of the forwarded location
  assign cfg_rdata = {cfg_offset, cfg_devfn ^ 8'h5A, cfg_bus, 8'h3C};

  cfg_bridge i_cfg_bridge (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_sel_i(req_sel), .req_off_i(req_off), .req_len_i(req_len),
    .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .tgt_bus_i(t_bus), .tgt_devfn_i(t_devfn), .tgt_present_i(t_pres),
    .tgt_powered_i(t_pwr), .tgt_hotplug_i(t_hp), .tgt_fn0_i(t_fn0),
    .cfg_valid_o(cfg_valid), .cfg_write_o(cfg_write), .cfg_tgt_o(cfg_tgt),
    .cfg_bus_o(cfg_bus), .cfg_devfn_o(cfg_devfn), .cfg_offset_o(cfg_offset),
    .cfg_len_o(cfg_len), .cfg_wdata_o(cfg_wdata), .cfg_rdata_i(cfg_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int m_idx(input logic [31:0] la);
    for (int i = 0; i < N; i++)
      if (t_pres[i] && t_bus[i] == la[23:16] && t_devfn[i] == la[15:8]) return i;
    return -1;
  endfunction

  function automatic bit m_allow(input logic [31:0] la, input logic [2:0] len);
    int i;
    i = m_idx(la);
    if (!la[31] || i < 0) return 0;
    if (!t_pwr[i] || (t_hp[i] && !t_fn0[i])) return 0;
    return (len >= 1 && len <= 4);
  endfunction

  function automatic logic [2:0] m_clip(input logic [7:0] off, input logic [2:0] len);
    int room;
    room = 256 - int'(off);
    return (int'(len) > room) ? 3'(room) : len;
  endfunction

  function automatic logic [31:0] m_rd(input logic [31:0] la, input logic [1:0] o, input logic [2:0] len);
    logic [7:0] off;
    logic [31:0] d;
    logic [2:0] cl;
    if (!m_allow(la, len)) return 32'hFFFF_FFFF;
    off = la[7:0] | {6'd0, o};
    d = {off, la[15:8] ^ 8'h5A, la[23:16], 8'h3C};
    cl = m_clip(off, len);
    for (int k = 0; k < 4; k++) if (k >= int'(cl)) d[8*k +: 8] = 8'hFF;
    return d;
  endfunction

  task automatic acc(input bit wr, input bit sel, input logic [1:0] off, input logic [2:0] len,
                     input logic [31:0] wd, input string tag);
    bit exp_ok;
    logic [31:0] exp_rd;
    logic [7:0] eoff;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_sel = sel;
    req_off = off; req_len = len; req_wdata = wd;
    #1;
    c_valid = cfg_valid; c_write = cfg_write; c_tgt = cfg_tgt; c_bus = cfg_bus;
    c_devfn = cfg_devfn; c_off = cfg_offset; c_len = cfg_len; c_wdata = cfg_wdata;
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    if (!sel) begin
      chk(c_valid == 1'b0, {tag, " R1 addr access forwards nothing"}, 32'(c_valid), 32'd0);
      if (wr) begin
        chk(rsp_valid == 1'b0, {tag, " R10 no rsp on write"}, 32'(rsp_valid), 32'd0);
        if (len == 3'd4 && off == 2'd0) m_latch = wd;
      end else begin
        chk(rsp_valid == 1'b1, {tag, " R10 rsp valid"}, 32'(rsp_valid), 32'd1);
        chk(rsp_rdata == m_latch, {tag, " R2 latch readback"}, rsp_rdata, m_latch);
      end
    end else begin
      exp_ok = m_allow(m_latch, len);
      chk(c_valid == exp_ok, {tag, " forward decision"}, 32'(c_valid), 32'(exp_ok));
      if (exp_ok && c_valid) begin
        eoff = m_latch[7:0] | {6'd0, off};
        chk(c_bus == m_latch[23:16] && c_devfn == m_latch[15:8],
            {tag, " R5 bus/devfn"}, {16'd0, c_bus, c_devfn}, {16'd0, m_latch[23:8]});
        chk(c_off == eoff, {tag, " R5 offset"}, 32'(c_off), 32'(eoff));
        chk(c_write == wr && c_wdata == wd, {tag, " R5 write data"}, c_wdata, wd);
        chk(c_len == m_clip(eoff, len), {tag, " R9 clipped len"}, 32'(c_len), 32'(m_clip(eoff, len)));
        chk(c_tgt == N'(1 << m_idx(m_latch)), {tag, " R12 target select"}, 32'(c_tgt),
            32'(1 << m_idx(m_latch)));
      end else begin
        chk(c_tgt == '0, {tag, " R12 no target when filtered"}, 32'(c_tgt), 32'd0);
      end
      if (wr) begin
        chk(rsp_valid == 1'b0, {tag, " R10 no rsp on write"}, 32'(rsp_valid), 32'd0);
      end else begin
        exp_rd = m_rd(m_latch, off, len);
        chk(rsp_valid == 1'b1, {tag, " R10 rsp valid"}, 32'(rsp_valid), 32'd1);
        chk(rsp_rdata == exp_rd, {tag, " R10 read data"}, rsp_rdata, exp_rd);
      end
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    void'($urandom(32'h1BAD_5EED));
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0 && cfg_valid == 1'b0, "R3 idle in reset", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R3 ready after reset", 32'(req_ready), 32'd1);
    acc(0, 0, 2'd0, 3'd4, '0, "R3 reset latch");
    chk(rsp_rdata == 32'd0, "R3 latch zero", rsp_rdata, 32'd0);

    t_pres = 4'b1111; t_pwr = 4'b1111; t_hp = '0; t_fn0 = '1;
    for (int i = 0; i < N; i++) begin t_bus[i] = 8'(i); t_devfn[i] = 8'h08; end
    acc(0, 1, 2'd0, 3'd4, '0, "R3 window disabled");
    acc(1, 0, 2'd0, 3'd2, 32'h8000_0800, "R1 short write");
    acc(1, 0, 2'd1, 3'd4, 32'h8000_0800, "R1 offset write");
    acc(0, 0, 2'd0, 3'd4, '0, "R1 latch unchanged");
    acc(1, 0, 2'd0, 3'd4, 32'h8000_08FC, "R1 load");
    acc(0, 0, 2'd2, 3'd1, '0, "R2 narrow read");
    acc(0, 1, 2'd3, 3'd4, '0, "R9 clip to 1");
    acc(0, 1, 2'd1, 3'd4, '0, "R9 clip to 3");
    acc(0, 1, 2'd0, 3'd2, '0, "R10 short read");
    acc(1, 1, 2'd2, 3'd2, 32'hDEAD_BEEF, "R5 write");
    acc(1, 0, 2'd0, 3'd4, 32'h0000_0810, "R4 disable");
    acc(0, 1, 2'd0, 3'd4, '0, "R4 disabled read");
    acc(1, 1, 2'd0, 3'd4, 32'h1234_5678, "R4 disabled write");
    acc(1, 0, 2'd0, 3'd4, 32'h8007_0810, "R6 set bus 7");
    acc(0, 1, 2'd0, 3'd4, '0, "R6 no match");
    acc(1, 0, 2'd0, 3'd4, 32'h8002_0810, "R7 set bus 2");
    t_pwr[2] = 1'b0;
    acc(0, 1, 2'd0, 3'd4, '0, "R7 unpowered read");
    acc(1, 1, 2'd0, 3'd4, 32'h5555_AAAA, "R7 unpowered write");
    t_pwr[2] = 1'b1; t_hp[2] = 1'b1; t_fn0[2] = 1'b0;
    acc(0, 1, 2'd0, 3'd4, '0, "R8 hidden read");
    acc(1, 1, 2'd0, 3'd4, 32'h0F0F_0F0F, "R8 hidden write");
    t_fn0[2] = 1'b1;
    acc(0, 1, 2'd0, 3'd4, '0, "R8 fn0 present");
    acc(0, 1, 2'd0, 3'd0, '0, "R11 len 0");
    acc(1, 1, 2'd0, 3'd5, 32'h1, "R11 len 5");
    t_bus[1] = 8'd3; t_bus[3] = 8'd3; t_devfn[1] = 8'h20; t_devfn[3] = 8'h20;
    acc(1, 0, 2'd0, 3'd4, 32'h8003_2040, "R12 set dup");
    acc(0, 1, 2'd0, 3'd4, '0, "R12 lowest index");

    for (int it = 0; it < 600; it++) begin
      int r;
      if (it % 25 == 0) begin
        for (int i = 0; i < N; i++) begin
          t_bus[i]   = 8'($urandom % 2);
          t_devfn[i] = 8'($urandom % 3) << 3;
        end
        t_pres = 4'($urandom); t_pwr = 4'($urandom | $urandom);
        t_hp = 4'($urandom); t_fn0 = 4'($urandom);
      end
      r = $urandom % 10;
      if (r < 2) begin
        logic [31:0] la;
        la = {($urandom % 4) != 0, 7'($urandom), 8'($urandom % 2),
              8'(($urandom % 3) << 3), 8'($urandom)};
        if ($urandom % 5 == 0) acc(1, 0, 2'($urandom), 3'($urandom), la, "R1 rand latch");
        else acc(1, 0, 2'd0, 3'd4, la, "R1 rand latch");
      end else if (r == 2) begin
        acc(0, 0, 2'($urandom), 3'(1 + $urandom % 4), '0, "R2 rand readback");
      end else begin
        logic [2:0] ln;
        ln = ($urandom % 8 == 0) ? 3'($urandom) : 3'(1 + $urandom % 4);
        acc(bit'($urandom), 1, 2'($urandom), ln, $urandom, "R5 rand data");
      end
    end
    finish_run();
  end
endmodule